// File: doc/BRIEF.md
# Synchronous Serial Shift Engine

This block moves one byte at a time over a clocked three-wire serial link. As a master it makes the transfer clock from the peripheral clock through a programmable divider and drives it out. As a slave it takes the transfer clock from outside, passes it through a synchroniser and acts on each of its transitions. The same datapath serves a synchronous USART and an SPI master. A clock-invert control and a phase control together select one of four clock polarity and phase arrangements.

A byte to send is offered on a valid/ready pair. The engine accepts it when `tx_valid` and `tx_ready` are both high on a clock edge. It then keeps `tx_ready` low until all eight bits have been exchanged, so a sender that holds `tx_valid` high waits without losing its byte. The receive side has no back-pressure: the captured byte appears with a one-cycle `rx_valid` strobe at the end of every frame, and the consumer must take it in that cycle.

The clock idles at the level given by `edge_inv` (low when 0, high when 1). The first transition of a bit period moves the clock away from that level and is called the leading edge. The second transition returns it and is called the trailing edge. Changing `edge_inv`, `phase_sel` or `master_en` while a frame is in progress corrupts that frame. Reset always recovers the engine.

Top module: `sync_ser_engine`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, `sck_oe` equals `master_en`, and in master mode `sck_o` rests at the idle level `edge_inv`.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the cycle in which `rx_valid` is raised, and it is 1 in that cycle.
- R3: In master mode, `sck_o` toggles exactly 16 times per frame. The first toggle comes `baud_div`+1 cycles after the accepting edge, and each later toggle follows the previous one by `baud_div`+1 cycles, so one bit lasts 2×(`baud_div`+1) cycles. `sck_o` returns to `edge_inv` at the end of the frame.
- R4: A frame is 8 bits. The accepted byte leaves on `sdo` with bit 7 first.
- R5: With `phase_sel`=1, `sdo` changes only on leading edges and `sdi` is sampled on trailing edges. With `edge_inv`=0 this means data changes on the rising edge and is sampled on the falling edge; with `edge_inv`=1 the roles of the two edges swap. `sdo` never changes except on a data-change edge or on acceptance.
- R6: With `phase_sel`=0, bit 7 is put on `sdo` in the cycle after acceptance, before the first clock edge. `sdi` is sampled on leading edges and `sdo` changes on trailing edges. No change follows the last trailing edge.
- R7: `rx_valid` is a one-cycle pulse in the cycle after the 16th clock edge. With it, `rx_data` holds the 8 sampled bits, the first sampled bit in bit 7.
- R8: With `master_en`=0, `sck_oe` is 0 and the engine shifts on the transitions of `sck_i` after a two-flop synchroniser, using the same edge roles as R5/R6. `sck_i` must stay stable for at least 4 peripheral clock cycles between transitions.
- R9: `tx_valid` and `tx_data` are ignored while `tx_ready` is 0: the byte in flight keeps going out unchanged.
- R10: A reset applied in the middle of a frame returns the engine to the R1 state, and the next frame works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Master clock divider; half bit period is baud_div+1 cycles |
| master_en | input | 1 | 1: drive the transfer clock; 0: follow sck_i |
| edge_inv | input | 1 | Clock idle level and edge-role inversion |
| phase_sel | input | 1 | 1: data changes on the leading edge; 0: data is set up before the first edge |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine can take a byte |
| tx_data | input | FRAME_BITS | Byte to send |
| rx_valid | output | 1 | One-cycle strobe: received byte is on rx_data |
| rx_data | output | FRAME_BITS | Received byte |
| sck_o | output | 1 | Transfer clock out (master) |
| sck_oe | output | 1 | Output enable for the transfer clock pin |
| sck_i | input | 1 | Transfer clock in (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong divider count or a stuck toggle level shows on `sck_o` within one half bit period: the spacing between toggles is off, or the number of toggles in a frame is not 16. A wrong edge index or a swapped edge role shows on `sdo` at the next data-change edge as a transition on the wrong clock direction. The same fault shows on `rx_data` at the end of the frame as shifted or out-of-order bits. A busy flag that fails to clear or to set shows on `tx_ready` and `rx_valid` in the cycle after the last edge or after acceptance. The bench sweeps every divider value up to 3 with all four polarity and phase arrangements in master mode, and all four arrangements in slave mode.

// File: rtl/sync_ser_pkg.sv
package sync_ser_pkg;
  // An edge samples the input when it is a leading edge and the phase is
  // early, or a trailing edge and the phase is late.
  function automatic logic edge_samples(input logic lead, input logic late_phase);
    return lead ^ late_phase;
  endfunction
endpackage

// File: rtl/ser_baud_gen.sv
module ser_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             level
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (cnt == div) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: with a divider above zero two ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/ser_clk_sync.sv
module ser_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi_in,
  output logic edge_seen,
  output logic sdi_sync
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] sdi_pipe;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      sdi_pipe <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_in};
      sck_prev <= sck_pipe[STAGES-1];
    end
  end

  assign edge_seen = sck_pipe[STAGES-1] ^ sck_prev;
  assign sdi_sync  = sdi_pipe[STAGES-1];
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
  import sync_ser_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  late_phase,
  input  logic                  fire,
  input  logic                  sdi_bit,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  sdo
);
  localparam int EDGES = 2 * FRAME_BITS;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(EDGES - 1);

  logic                  busy;
  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;
  logic                  smp;
  logic                  last;
  logic                  accept;

  assign tx_ready = !busy;
  assign accept   = tx_valid && !busy;
  assign smp      = edge_samples(!idx[0], late_phase);
  assign last     = (idx == LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sdo      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        rx_sh <= '0;
        if (late_phase) begin
          tx_sh <= tx_data;
        end else begin
          sdo   <= tx_data[FRAME_BITS-1];
          tx_sh <= {tx_data[FRAME_BITS-2:0], 1'b0};
        end
      end else if (busy && fire) begin
        idx <= idx + 1'b1;
        if (smp) begin
          rx_sh <= {rx_sh[FRAME_BITS-2:0], sdi_bit};
        end else if (!last) begin
          sdo   <= tx_sh[FRAME_BITS-1];
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        end
        if (last) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= smp ? {rx_sh[FRAME_BITS-2:0], sdi_bit} : rx_sh;
        end
      end
    end
  end

  // R2: a taken byte blocks the next one
  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R2: the end of frame frees the input
  assert_done_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> tx_ready);
  // R7: the receive strobe lasts one cycle and follows a clock edge
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_strobe_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fire));
  // R5: data out moves only on an edge or on acceptance
  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy && fire) && !accept) |=> $stable(sdo));
endmodule

// File: rtl/sync_ser_engine.sv
module sync_ser_engine #(
  parameter int FRAME_BITS  = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      baud_div,
  input  logic                  master_en,
  input  logic                  edge_inv,
  input  logic                  phase_sel,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  rx_valid,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  sck_o,
  output logic                  sck_oe,
  input  logic                  sck_i,
  output logic                  sdo,
  input  logic                  sdi
);
  logic m_tick;
  logic m_level;
  logic s_edge;
  logic s_sdi;
  logic fire;
  logic sdi_bit;

  ser_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (master_en && !tx_ready),
    .div   (baud_div),
    .tick  (m_tick),
    .level (m_level)
  );

  ser_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_in    (sck_i),
    .sdi_in    (sdi),
    .edge_seen (s_edge),
    .sdi_sync  (s_sdi)
  );

  assign fire    = master_en ? m_tick : s_edge;
  assign sdi_bit = master_en ? sdi    : s_sdi;

  ser_shift_core #(.FRAME_BITS(FRAME_BITS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .late_phase (phase_sel),
    .fire       (fire),
    .sdi_bit    (sdi_bit),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .sdo        (sdo)
  );

  assign sck_o  = m_level ^ edge_inv;
  assign sck_oe = master_en;

  // R3: an idle master holds the clock at its idle level
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && tx_ready) |-> (sck_o == edge_inv));
endmodule

// File: tb/sync_ser_engine_test.sv
module sync_ser_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud_div = '0;
  logic       master_en = 1'b1;
  logic       edge_inv = 1'b0;
  logic       phase_sel = 1'b1;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       sck_o;
  logic       sck_oe;
  logic       sck_i = 1'b0;
  logic       sdo;
  logic       sdi = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_ser_engine uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .master_en(master_en),
    .edge_inv(edge_inv), .phase_sel(phase_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_frame(input int dv, input logic iv, input logic ph,
                              input logic [7:0] b_tx, input logic [7:0] b_rx, input bit junk);
    int t; int last; int tog; int nb;
    logic prev_sck; logic prev_sdo; logic [7:0] got; bit done; bit lead; bit smp;
    @(negedge clk);
    baud_div = 8'(dv); edge_inv = iv; phase_sel = ph; master_en = 1'b1;
    @(negedge clk);
    check(sck_o == iv, "R3 idle level before frame", sck_o, iv);
    sdi = ph ? 1'b0 : b_rx[7];
    tx_data = b_tx; tx_valid = 1'b1;
    @(negedge clk);
    if (junk) tx_data = ~b_tx; else tx_valid = 1'b0;
    check(!tx_ready, "R2 busy after accept", tx_ready, 0);
    if (!ph) check(sdo == b_tx[7], "R6 first bit before first edge", sdo, b_tx[7]);
    prev_sck = sck_o; prev_sdo = sdo; t = 1; last = 1; tog = 0; nb = 0; got = '0; done = 0;
    while (!done && t < 600) begin
      @(negedge clk);
      t++;
      if (sck_o != prev_sck) begin
        check(t - last == dv + 1, "R3 toggle spacing", t - last, dv + 1);
        last = t;
        lead = (tog % 2 == 0);
        smp = ph ? !lead : lead;
        if (smp) begin
          check(sdo == prev_sdo, "R5 sdo steady on sample edge", sdo, prev_sdo);
          got = {got[6:0], sdo};
          nb++;
        end else begin
          check(sck_o == (ph ? !iv : iv), "R5 data-change edge direction", sck_o, ph ? !iv : iv);
          if (nb < 8) sdi = b_rx[7 - nb];
        end
        tog++;
        prev_sck = sck_o;
      end else if (sdo != prev_sdo) begin
        check(0, "R5 sdo moved without edge", sdo, prev_sdo);
      end
      prev_sdo = sdo;
      if (rx_valid) begin
        done = 1;
        tx_valid = 1'b0;
        check(rx_data == b_rx, "R7 received byte", rx_data, b_rx);
        check(tog == 16, "R3 toggles per frame", tog, 16);
        check(got == b_tx, junk ? "R9 byte in flight unchanged" : "R4 msb-first byte out", got, b_tx);
        check(tx_ready, "R2 ready with strobe", tx_ready, 1);
        check(sck_o == iv, "R3 idle level after frame", sck_o, iv);
      end
    end
    tx_valid = 1'b0;
    check(done, "R7 strobe seen", done, 1);
    @(negedge clk);
    check(!rx_valid, "R7 strobe one cycle", rx_valid, 0);
    if (junk) check(tx_ready, "R9 no extra accept", tx_ready, 1);
  endtask

  task automatic slave_frame(input logic iv, input logic ph,
                             input logic [7:0] b_tx, input logic [7:0] b_rx);
    int nb; logic [7:0] got; bit done; bit lead; bit smp;
    @(negedge clk);
    master_en = 1'b0; edge_inv = iv; phase_sel = ph; sck_i = iv;
    repeat (6) @(negedge clk);
    check(!sck_oe, "R8 clock pin not driven", sck_oe, 0);
    sdi = ph ? 1'b0 : b_rx[7];
    tx_data = b_tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    nb = 0; got = '0; done = 0;
    for (int e = 0; e < 16; e++) begin
      lead = (e % 2 == 0);
      smp = ph ? !lead : lead;
      repeat (8) @(negedge clk);
      if (smp) begin
        got = {got[6:0], sdo};
        nb++;
      end
      sck_i = ~sck_i;
      if (!smp && nb < 8) sdi = b_rx[7 - nb];
    end
    for (int w = 0; w < 12 && !done; w++) begin
      @(negedge clk);
      if (rx_valid) begin
        done = 1;
        check(rx_data == b_rx, "R8 slave received byte", rx_data, b_rx);
      end
    end
    check(done, "R8 slave strobe seen", done, 1);
    check(got == b_tx, "R8 slave byte out", got, b_tx);
    check(tx_ready, "R8 slave ready after frame", tx_ready, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] a; logic [7:0] b; int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready, "R1 ready after reset", tx_ready, 1);
    check(!rx_valid, "R1 no strobe after reset", rx_valid, 0);
    check(sck_oe == master_en, "R1 clock enable", sck_oe, master_en);
    check(sck_o == edge_inv, "R1 idle clock", sck_o, edge_inv);

    n = 0;
    for (int dv = 0; dv < 4; dv++)
      for (int iv = 0; iv < 2; iv++)
        for (int ph = 0; ph < 2; ph++)
          for (int k = 0; k < 2; k++) begin
            a = 8'(8'hA5 ^ (n * 37));
            b = 8'(8'h3C + n * 91);
            master_frame(dv, iv[0], ph[0], a, b, 1'b0);
            n++;
          end
    master_frame(1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0);
    master_frame(0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    // R9: offers during a frame are ignored
    master_frame(2, 1'b0, 1'b1, 8'h96, 8'h5A, 1'b1);
    master_frame(1, 1'b1, 1'b0, 8'h4B, 8'hC3, 1'b1);

    for (int iv = 0; iv < 2; iv++)
      for (int ph = 0; ph < 2; ph++)
        slave_frame(iv[0], ph[0], 8'(8'hD2 ^ (iv * 17 + ph * 5)), 8'(8'h69 + iv * 3 + ph * 40));

    // R10: reset in the middle of a frame
    @(negedge clk);
    master_en = 1'b1; baud_div = 8'd3; edge_inv = 1'b1; phase_sel = 1'b1;
    tx_data = 8'h77; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(!tx_ready, "R10 busy before reset", tx_ready, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready, "R10 ready after reset", tx_ready, 1);
    check(!rx_valid, "R10 no strobe after reset", rx_valid, 0);
    check(sck_o == edge_inv, "R10 idle clock after reset", sck_o, edge_inv);
    master_frame(3, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule